// File: doc/BRIEF.md
# Programming host sequencer

This block sits on the host side of a four-wire serial programming link into a microcontroller-style target. On a start strobe it brings the target into programming mode. It holds the serial clock low, pulses the target reset line, waits out the power-up delay and sends the 32-bit programming-enable command. While the third byte of that command is being shifted, it watches the byte the target echoes back. If the echo is wrong, it finishes the command, pulses reset again and retries. After a set number of failed attempts it gives up and raises `error`.

Once the target is in programming mode, the sequencer writes one flash page. When the upper address byte has changed, or has not been sent since the last enable, it sends it first. It then fetches the page's words one at a time over a request/valid port. For each word it sends a low-byte load and then a high-byte load. At the end of the page it sends the page-write command, waits out the flash write time and pulses `done`.

A later start while the target is still in programming mode goes straight to the page. Blank words (0xFFFF) can be dropped, which suits a target that was chip-erased before. Every delay and the serial clock phase length are given in system clocks as parameters.

Top module: `pgm_host_seq`

## Requirements
- R1: The serial clock stays low whenever the target reset output is high. After reset, `sck`, `tgt_rst`, `done`, `error` and `word_req` are all low.
- R2: Before every enable attempt, `tgt_rst` goes high for exactly RST_CLKS system clocks.
- R3: The first `sck` rise after a reset pulse comes no earlier than PWR_CLKS clocks after `tgt_rst` falls.
- R4: The enable command is the frame 0xAC530000, sent most significant bit first. All 32 bits are always sent. `miso` is sampled at each `sck` rise, and the attempt passes only when bits 16..23 of the frame (the third byte) read back 0x53.
- R5: A failed echo starts a new reset pulse and enable. After MAX_TRIES consecutive failures, `error` goes high and `sck`, `tgt_rst` and `word_req` stay low until the next start.
- R6: The upper-address frame {0x4D, 0x00, addr[23:16], 0x00} is sent before the first page after each enable. After that it is sent only when addr[23:16] of the page differs from the value last sent.
- R7: Words are requested in offset order. A word is accepted in a cycle where `word_req` and `word_valid` are both high. For each word, {0x40, 0x00, offset, low byte} is sent before {0x48, 0x00, offset, high byte}.
- R8: With SKIP_BLANK=1, a word equal to 0xFFFF is accepted but produces no frame.
- R9: After the last word, {0x4C, addr[15:8], addr[7:0], 0x00} is sent, using the page base address (the low offset bits cleared). `done` is a one-cycle pulse no earlier than WR_CLKS clocks after the final `sck` fall.
- R10: Each `sck` phase lasts at least PHASE_CLKS clocks, and `mosi` does not change while `sck` is high.
- R11: A start while the target is still in programming mode sends no reset pulse and no enable command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one page (with entry to programming mode if needed) |
| base_addr | input | ADDR_W | Word address of the page |
| word_req | output | 1 | Sequencer is waiting for the next word |
| word_valid | input | 1 | Word on `word_data` is available |
| word_data | input | 16 | Flash word |
| miso | input | 1 | Serial data from the target |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| tgt_rst | output | 1 | Target reset line level |
| done | output | 1 | Page finished (one-cycle pulse) |
| error | output | 1 | Enable retries exhausted |

## Verification
The bench builds the block with PAGE_WORDS=4, PHASE_CLKS=2, RST_CLKS=3, PWR_CLKS=20, WR_CLKS=30 and MAX_TRIES=3. Small values like these keep each page to a few hundred clocks, so the run can include a retry that succeeds, a run of failures that exhausts the retries, recovery from that error, and a page with blank words. With four-word pages, changing the upper address only needs a base of 0x10000. That makes both the first-page and the boundary-crossing cases of the upper-address frame reachable in a short run.

// File: rtl/pgm_host_seq.sv
module pgm_host_seq #(
  parameter int ADDR_W     = 17,
  parameter int PAGE_WORDS = 128,
  parameter int PHASE_CLKS = 3,
  parameter int RST_CLKS   = 4,
  parameter int PWR_CLKS   = 2_000_000,
  parameter int WR_CLKS    = 500_000,
  parameter int MAX_TRIES  = 4,
  parameter bit SKIP_BLANK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              word_req,
  input  logic              word_valid,
  input  logic [15:0]       word_data,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              tgt_rst,
  output logic              done,
  output logic              error
);
  localparam int OFF_W = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [31:0] PH_M1  = 32'(PHASE_CLKS - 1);
  localparam logic [31:0] RST_M1 = 32'(RST_CLKS - 1);
  localparam logic [31:0] PWR_M1 = 32'(PWR_CLKS - 1);
  localparam logic [31:0] WR_M1  = 32'(WR_CLKS - 1);
  localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(PAGE_WORDS - 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);
  localparam logic [23:0] PG_MASK = ~24'(PAGE_WORDS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST, S_PWR, S_XFER, S_CHK, S_EXT, S_GETW,
    S_HI, S_NEXT, S_WAIT, S_DONE, S_ERR
  } st_t;

  st_t              st, ret;
  logic [31:0]      cnt, sr;
  logic [7:0]       rx, ext_q, whi;
  logic [4:0]       bitn;
  logic             sck_q, enabled, ext_ok;
  logic [OFF_W-1:0] off;
  logic [TRY_W-1:0] tries;
  logic [23:0]      base_q;

  wire [23:0] page_base = 24'(base_addr) & PG_MASK;
  wire [7:0]  off8      = 8'(off);
  wire        ext_need  = !ext_ok || (ext_q != base_q[23:16]);
  wire        blank     = SKIP_BLANK && (word_data == 16'hFFFF);

  assign sck      = sck_q;
  assign mosi     = sr[31];
  assign tgt_rst  = (st == S_RST);
  assign word_req = (st == S_GETW);
  assign done     = (st == S_DONE);
  assign error    = (st == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  ret <= S_IDLE;  cnt <= '0;  sr <= '0;  rx <= '0;
      bitn <= '0;  sck_q <= 1'b0;  off <= '0;  tries <= '0;
      enabled <= 1'b0;  ext_ok <= 1'b0;  ext_q <= '0;  whi <= '0;  base_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          base_q <= page_base;
          off    <= '0;
          tries  <= '0;
          cnt    <= '0;
          st     <= enabled ? S_EXT : S_RST;
        end
        S_ERR: if (start) begin
          base_q <= page_base;
          off    <= '0;
          tries  <= '0;
          cnt    <= '0;
          st     <= S_RST;
        end
        S_RST: begin
          enabled <= 1'b0;
          ext_ok  <= 1'b0;
          if (cnt == RST_M1) begin
            cnt <= '0;
            st  <= S_PWR;
          end else cnt <= cnt + 1'b1;
        end
        S_PWR: if (cnt == PWR_M1) begin
          sr <= 32'hAC53_0000;  bitn <= '0;  cnt <= '0;
          ret <= S_CHK;  st <= S_XFER;
        end else cnt <= cnt + 1'b1;
        S_XFER: if (cnt == PH_M1) begin
          cnt <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            if (bitn[4:3] == 2'b10) rx <= {rx[6:0], miso};
          end else begin
            sck_q <= 1'b0;
            sr    <= {sr[30:0], 1'b0};
            if (bitn == 5'd31) st <= ret;
            else bitn <= bitn + 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        S_CHK: begin
          cnt <= '0;
          if (rx == 8'h53) begin
            enabled <= 1'b1;
            tries   <= '0;
            st      <= S_EXT;
          end else if (tries == TRY_LAST) begin
            st <= S_ERR;
          end else begin
            tries <= tries + 1'b1;
            st    <= S_RST;
          end
        end
        S_EXT: if (ext_need) begin
          ext_ok <= 1'b1;
          ext_q  <= base_q[23:16];
          sr <= {8'h4D, 8'h00, base_q[23:16], 8'h00};  bitn <= '0;  cnt <= '0;
          ret <= S_GETW;  st <= S_XFER;
        end else st <= S_GETW;
        S_GETW: if (word_valid) begin
          whi <= word_data[15:8];
          if (blank) st <= S_NEXT;
          else begin
            sr <= {8'h40, 8'h00, off8, word_data[7:0]};  bitn <= '0;  cnt <= '0;
            ret <= S_HI;  st <= S_XFER;
          end
        end
        S_HI: begin
          sr <= {8'h48, 8'h00, off8, whi};  bitn <= '0;  cnt <= '0;
          ret <= S_NEXT;  st <= S_XFER;
        end
        S_NEXT: if (off == OFF_LAST) begin
          sr <= {8'h4C, base_q[15:8], base_q[7:0], 8'h00};  bitn <= '0;  cnt <= '0;
          ret <= S_WAIT;  st <= S_XFER;
        end else begin
          off <= off + 1'b1;
          st  <= S_GETW;
        end
        S_WAIT: if (cnt == WR_M1) begin
          cnt <= '0;
          st  <= S_DONE;
        end else cnt <= cnt + 1'b1;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgm_host_seq_chk.sv
module pgm_host_seq_chk #(
  parameter int PHASE_CLKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic sck,
  input logic mosi,
  input logic tgt_rst,
  input logic word_req,
  input logic done,
  input logic error
);
  logic        sck_d;
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      run   <= '0;
    end else begin
      sck_d <= sck;
      if (sck != sck_d) run <= 32'd1;
      else if (run != 32'hFFFF_FFFF) run <= run + 1'b1;
    end
  end

  AST_SCK_LOW_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst |-> !sck); // R1
  AST_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != sck_d) |-> (run >= 32'(PHASE_CLKS))); // R10
  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!sck && !tgt_rst && !word_req)); // R5
  AST_REQ_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    word_req |-> !sck); // R7
endmodule

bind pgm_host_seq pgm_host_seq_chk #(.PHASE_CLKS(PHASE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .tgt_rst(tgt_rst),
  .word_req(word_req), .done(done), .error(error)
);

// File: tb/pgm_host_seq_tb.sv
module pgm_host_seq_tb;
  localparam int PH = 2, RSTC = 3, PWR = 20, WR = 30, TRIES = 3;

  logic clk = 0, rst_n = 0, start = 0, word_valid = 0;
  logic [16:0] base_addr = '0;
  logic [15:0] word_data = '0;
  logic word_req, miso, sck, mosi, tgt_rst, done, error;

  pgm_host_seq #(.ADDR_W(17), .PAGE_WORDS(4), .PHASE_CLKS(PH), .RST_CLKS(RSTC),
    .PWR_CLKS(PWR), .WR_CLKS(WR), .MAX_TRIES(TRIES), .SKIP_BLANK(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_req(word_req), .word_valid(word_valid), .word_data(word_data),
    .miso(miso), .sck(sck), .mosi(mosi), .tgt_rst(tgt_rst), .done(done), .error(error));

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  bit fin = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_q[$];
  string tag_q[$];
  task automatic expect_frame(input logic [31:0] f, input string tag);
    exp_q.push_back(f);
    tag_q.push_back(tag);
  endtask

  // target model
  int n = 0, fails_left = 0;
  logic [31:0] frm = '0;
  wire [7:0] echo = (fails_left > 0) ? 8'h00 : 8'h53;
  assign miso = (n >= 16 && n < 24) ? echo[23-n] : 1'b0;

  always @(posedge tgt_rst or negedge rst_n) n = 0;

  always @(posedge sck) begin
    frm = {frm[30:0], mosi};
    n = n + 1;
    if (n == 32) begin
      n = 0;
      if (frm == 32'hAC53_0000 && fails_left > 0) fails_left--;
      if (exp_q.size() == 0) chk(0, "R6 unexpected frame", frm, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(frm == e, t, frm, e);
      end
    end
  end

  // port monitor, sampled away from the active edge
  int cyc = 0, pulses = 0, rst_w = 0, req_cyc = 0, done_cnt = 0;
  int last_fall = 0, rst_fall = 0;
  bit gap_pend = 0, prev_rst = 0, prev_sck = 0;
  always @(negedge clk) begin
    cyc++;
    if (tgt_rst) rst_w++;
    if (tgt_rst && !prev_rst) pulses++;
    if (!tgt_rst && prev_rst) begin
      chk(rst_w == RSTC, "R2 reset pulse width", rst_w, RSTC);
      rst_w = 0;
      rst_fall = cyc;
      gap_pend = 1;
    end
    if (sck && !prev_sck && gap_pend) begin
      chk(cyc - rst_fall >= PWR, "R3 power-up wait", cyc - rst_fall, PWR);
      gap_pend = 0;
    end
    if (!sck && prev_sck) last_fall = cyc;
    if (word_req) req_cyc++;
    if (done) begin
      done_cnt++;
      chk(cyc - last_fall >= WR, "R9 write delay", cyc - last_fall, WR);
    end
    prev_rst = tgt_rst;
    prev_sck = sck;
  end

  // word source
  logic [15:0] wq[$];
  bit took = 0;
  always @(posedge clk) took = word_req && word_valid;
  always @(negedge clk) begin
    if (word_valid && took) word_valid = 0;
    if (!word_valid && word_req && wq.size() > 0) begin
      word_valid = 1;
      word_data  = wq.pop_front();
    end
  end

  task automatic run_page(input logic [16:0] a);
    pulses = 0; done_cnt = 0; req_cyc = 0;
    @(negedge clk);
    base_addr = a;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_cnt > 0 || error) break;
    end
  endtask

  task automatic check_reset(input string tag);
    chk(!sck && !tgt_rst && !done && !error && !word_req, tag,
        {sck, tgt_rst, done, error, word_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset("R12 reset state");
    chk(!sck && !tgt_rst, "R1 idle levels", {sck, tgt_rst}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // A: one failed sync, then a page with a blank word
    fails_left = 1;
    expect_frame(32'hAC53_0000, "R4 enable (failed echo)");
    expect_frame(32'hAC53_0000, "R5 retried enable");
    expect_frame(32'h4D00_0000, "R6 first upper address");
    expect_frame(32'h4000_0034, "R7 low byte w0");
    expect_frame(32'h4800_0012, "R7 high byte w0");
    expect_frame(32'h4000_02CD, "R8 w1 skipped, low w2");
    expect_frame(32'h4800_02AB, "R7 high byte w2");
    expect_frame(32'h4000_03FF, "R7 low byte w3");
    expect_frame(32'h4800_0300, "R7 high byte w3");
    expect_frame(32'h4C00_1000, "R9 page write");
    wq = '{16'h1234, 16'hFFFF, 16'hABCD, 16'h00FF};
    run_page(17'h00012);
    chk(done_cnt == 1, "R9 done pulse", done_cnt, 1);
    chk(pulses == 2, "R5 reset pulses on retry", pulses, 2);
    chk(exp_q.size() == 0, "R7 all frames seen", exp_q.size(), 0);
    chk(!error, "R5 no error", error, 0);

    // B: still enabled, same upper address
    expect_frame(32'h4000_0001, "R11 low w0");
    expect_frame(32'h4800_0000, "R11 high w0");
    expect_frame(32'h4000_0102, "R7 low w1");
    expect_frame(32'h4800_0100, "R7 high w1");
    expect_frame(32'h4C00_1400, "R9 page write B");
    wq = '{16'h0001, 16'h0002, 16'hFFFF, 16'hFFFF};
    run_page(17'h00014);
    chk(pulses == 0, "R11 no reset pulse", pulses, 0);
    chk(done_cnt == 1, "R9 done B", done_cnt, 1);
    chk(exp_q.size() == 0, "R8 blank words sent nothing", exp_q.size(), 0);

    // C: upper address change
    expect_frame(32'h4D00_0100, "R6 upper address change");
    expect_frame(32'h4000_035A, "R8 low w3");
    expect_frame(32'h4800_035A, "R8 high w3");
    expect_frame(32'h4C00_0000, "R9 page write C");
    wq = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h5A5A};
    run_page(17'h10000);
    chk(done_cnt == 1, "R9 done C", done_cnt, 1);
    chk(exp_q.size() == 0, "R6 frames C", exp_q.size(), 0);

    // D: retries exhausted
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check_reset("R12 reset state again");
    rst_n = 1;
    fails_left = 99;
    for (int i = 0; i < TRIES; i++) expect_frame(32'hAC53_0000, "R5 failing enable");
    run_page(17'h00000);
    chk(error, "R5 error raised", error, 1);
    chk(pulses == TRIES, "R5 attempt count", pulses, TRIES);
    chk(req_cyc == 0, "R5 no word request", req_cyc, 0);
    chk(done_cnt == 0, "R5 no done", done_cnt, 0);
    repeat (200) @(negedge clk);
    chk(error && exp_q.size() == 0, "R5 stays quiet", error, 1);

    // E: recover from error
    fails_left = 0;
    expect_frame(32'hAC53_0000, "R4 enable ok");
    expect_frame(32'h4D00_0000, "R6 upper address after re-enable");
    expect_frame(32'h4000_0011, "R7 low E");
    expect_frame(32'h4800_0022, "R7 high E");
    expect_frame(32'h4C00_0000, "R9 page write E");
    wq = '{16'h2211, 16'hFFFF, 16'hFFFF, 16'hFFFF};
    run_page(17'h00003);
    chk(!error && done_cnt == 1, "R5 recovery", done_cnt, 1);
    chk(pulses == 1, "R2 single pulse", pulses, 1);
    chk(exp_q.size() == 0, "R9 frames E", exp_q.size(), 0);

    fin = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule